// File: doc/BRIEF.md
# Sparse Weighted Current Accumulator

This block builds the synaptic input current for a group of four output-layer neurons in a two-layer spiking network. During one accumulation phase it walks the firing lists held by several input-layer processing elements over a shared bus. It is the only master on that bus and grants one element at a time. Each index read from a list names an input neuron that fired in the previous step. That index, together with the selected output group, goes out as an address to an external weight memory. The memory has a fixed read latency and accepts one address per cycle.

Every word returned by the memory is 64 bits wide and carries four signed 16-bit weights, each with 12 fractional bits. Each weight belongs to one of the four output neurons of the group. The block splits the word into its four weights and adds them into four accumulators in parallel. Once every response has come back, it presents the four summed currents for write into the output-layer state memory. Input neurons that did not fire cost no cycles. Addresses leave back to back, so the memory pipeline stays full for the whole phase.

Top module: `spike_current_accum`

## Requirements
- R1: While reset is high and after its release, `busy`, `done`, `cur_valid`, `mem_req` and every bit of `bus_gnt` are 0, and `cur_data` is 0.
- R2: At most one bit of `bus_gnt` is high in any cycle. A grant to element p only carries a `bus_ptr` below that element's count. Elements are served in ascending number, and within one element the entries are served from 0 upward. Elements with a zero count are skipped.
- R3: `mem_addr` carries the group in its upper 4 bits and the list index in its lower 8 bits. Within a phase, requests form one unbroken run of cycles, with no idle cycle even where the walk moves from one element to the next.
- R4: Returned word bits [16j+15:16j] hold the two's-complement weight for lane j (12 fractional bits). The sum for lane j appears at `cur_data` bits [22j+21:22j].
- R5: Each lane's result equals the sum of its weights over the listed indices of this phase only. The accumulators restart from zero at every accepted start.
- R6: The 22-bit lane sums hold the extreme totals of 32 weights of -32768 or 32767 each without wrapping.
- R7: `done` and `cur_valid` rise together for one cycle, and only after the response to every issued address has been received. `cur_grp` equals the group given at start, and the number of responses equals the number of list entries.
- R8: If every count is zero at start, `done` is high in the next cycle with `cur_valid` low, no address is issued, and `cur_data` keeps its previous value.
- R9: `busy` is high from the cycle after an accepted start of a non-empty phase until the cycle in which `done` is high, when it is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one accumulation phase (taken only while idle) |
| grp_sel | input | 4 | Output-neuron group whose four currents are built |
| pe_count | input | 16 | Per-element count of fired entries, 4 bits each, element 0 lowest |
| busy | output | 1 | Phase in progress |
| done | output | 1 | One-cycle end-of-phase pulse |
| bus_gnt | output | 4 | One-hot grant to a processing element |
| bus_ptr | output | 3 | Entry of the granted element's firing list |
| bus_idx | input | 8 | Input-neuron index driven by the granted element |
| mem_req | output | 1 | Weight memory read request |
| mem_addr | output | 12 | Weight memory address {group, index} |
| mem_rvalid | input | 1 | Weight memory response valid |
| mem_rdata | input | 64 | Four packed 16-bit weights |
| cur_valid | output | 1 | Write strobe for the output-layer currents |
| cur_grp | output | 4 | Group of the presented currents |
| cur_data | output | 88 | Four 22-bit signed currents, lane 0 lowest |

## Verification
The assertions take the element counts and the group select to be steady from start until `done`. They also expect the memory to send exactly one response per request and never a response with none pending. The bench meets this by changing counts and group only while the block is idle. Its memory model is a fixed-depth shift line that answers each sampled request exactly once, so in-flight reads never exceed the latency. Weights are computed from the address, so extreme values reach the accumulators only through chosen indices.

// File: rtl/spike_acc_pkg.sv
package spike_acc_pkg;

  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  // Sign-extend helper width check value used by the lane adders.
  function automatic int sum_width(int weight_w, int max_terms);
    return weight_w + $clog2(max_terms + 1);
  endfunction

endpackage

// File: rtl/spike_bus_arbiter.sv
module spike_bus_arbiter #(
  parameter int NUM_PE = 4,
  parameter int CNT_W  = 4,
  parameter int PTR_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [NUM_PE*CNT_W-1:0] pe_count,
  output logic                    any_fired,
  output logic                    run,
  output logic [NUM_PE-1:0]       gnt,
  output logic [PTR_W-1:0]        ptr
);

  localparam int PE_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1;

  logic [PE_W-1:0]   sel_pe;
  logic [PE_W-1:0]   first_pe;
  logic [PE_W-1:0]   next_pe;
  logic              next_found;
  logic [CNT_W-1:0]  sel_ptr;
  logic [CNT_W-1:0]  sel_cnt;
  logic [NUM_PE-1:0] gnt_d;

  // Look-ahead: first non-empty element overall, and first above the current one
  always_comb begin
    any_fired  = 1'b0;
    first_pe   = '0;
    next_found = 1'b0;
    next_pe    = '0;
    for (int p = NUM_PE - 1; p >= 0; p--) begin
      if (pe_count[p*CNT_W +: CNT_W] != '0) begin
        any_fired = 1'b1;
        first_pe  = PE_W'(p);
        if (p > int'(sel_pe)) begin
          next_found = 1'b1;
          next_pe    = PE_W'(p);
        end
      end
    end
  end

  always_comb begin
    sel_cnt = pe_count[int'(sel_pe)*CNT_W +: CNT_W];
    gnt_d   = '0;
    gnt_d[sel_pe] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      sel_pe  <= '0;
      sel_ptr <= '0;
      gnt     <= '0;
      ptr     <= '0;
    end else begin
      gnt <= '0;
      if (start && any_fired) begin
        run     <= 1'b1;
        sel_pe  <= first_pe;
        sel_ptr <= '0;
      end else if (run) begin
        gnt <= gnt_d;
        ptr <= PTR_W'(sel_ptr);
        if ((sel_ptr + 1'b1) != sel_cnt) begin
          sel_ptr <= sel_ptr + 1'b1;
        end else if (next_found) begin
          sel_pe  <= next_pe;
          sel_ptr <= '0;
        end else begin
          run <= 1'b0;
        end
      end
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt)); // R2

  for (genvar p = 0; p < NUM_PE; p++) begin : g_range_chk
    AST_GNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      gnt[p] |-> (CNT_W'(ptr) < pe_count[p*CNT_W +: CNT_W])); // R2
  end

endmodule

// File: rtl/spike_req_issue.sv
module spike_req_issue #(
  parameter int IDX_W   = 8,
  parameter int GRP_W   = 4,
  parameter int MEM_LAT = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fetch,
  input  logic [IDX_W-1:0]       bus_idx,
  input  logic [GRP_W-1:0]       grp,
  input  logic                   mem_rvalid,
  output logic                   mem_req,
  output logic [GRP_W+IDX_W-1:0] mem_addr,
  output logic                   drained
);

  localparam int OUT_W = $clog2(MEM_LAT + 2);

  logic [OUT_W-1:0] outst;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      outst    <= '0;
    end else begin
      mem_req <= fetch;
      if (fetch) begin
        mem_addr <= {grp, bus_idx};
      end
      case ({mem_req, mem_rvalid})
        2'b10:   outst <= outst + 1'b1;
        2'b01:   outst <= outst - 1'b1;
        default: outst <= outst;
      endcase
    end
  end

  assign drained = !mem_req && (outst == '0);

  AST_STRAY_RVALID: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |-> (outst != '0)); // R7
  AST_OUTST_BOUND: assert property (@(posedge clk) disable iff (rst)
    outst <= OUT_W'(MEM_LAT + 1)); // R7

endmodule

// File: rtl/spike_lane_accum.sv
module spike_lane_accum #(
  parameter int LANES    = 4,
  parameter int WEIGHT_W = 16,
  parameter int ACC_W    = 22
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      add,
  input  logic [LANES*WEIGHT_W-1:0] rdata,
  output logic [LANES*ACC_W-1:0]    acc
);

  localparam int EXT_W = ACC_W - WEIGHT_W;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [WEIGHT_W-1:0] w_raw;
    logic [ACC_W-1:0]    addend;
    logic [ACC_W-1:0]    acc_q;
    logic [ACC_W-1:0]    sum;

    always_comb begin
      w_raw  = rdata[j*WEIGHT_W +: WEIGHT_W];
      addend = {{EXT_W{w_raw[WEIGHT_W-1]}}, w_raw};
      sum    = acc_q + addend;
    end

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        acc_q <= '0;
      end else if (add) begin
        acc_q <= sum;
      end
    end

    assign acc[j*ACC_W +: ACC_W] = acc_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (add && !clr && (acc_q[ACC_W-1] == addend[ACC_W-1])) |-> (sum[ACC_W-1] == acc_q[ACC_W-1])); // R6
  end

endmodule

// File: rtl/spike_current_accum.sv
module spike_current_accum
  import spike_acc_pkg::*;
#(
  parameter int NUM_PE     = 4,
  parameter int LIST_DEPTH = 8,
  parameter int IDX_W      = 8,
  parameter int GRP_W      = 4,
  parameter int LANES      = 4,
  parameter int WEIGHT_W   = 16,
  parameter int MEM_LAT    = 11,
  localparam int CNT_W     = $clog2(LIST_DEPTH + 1),
  localparam int PTR_W     = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1,
  localparam int ADDR_W    = GRP_W + IDX_W,
  localparam int ACC_W     = sum_width(WEIGHT_W, NUM_PE * LIST_DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [GRP_W-1:0]          grp_sel,
  input  logic [NUM_PE*CNT_W-1:0]   pe_count,
  output logic                      busy,
  output logic                      done,
  output logic [NUM_PE-1:0]         bus_gnt,
  output logic [PTR_W-1:0]          bus_ptr,
  input  logic [IDX_W-1:0]          bus_idx,
  output logic                      mem_req,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic                      mem_rvalid,
  input  logic [LANES*WEIGHT_W-1:0] mem_rdata,
  output logic                      cur_valid,
  output logic [GRP_W-1:0]          cur_grp,
  output logic [LANES*ACC_W-1:0]    cur_data
);

  phase_e             phase_q;
  logic [GRP_W-1:0]   grp_q;
  logic               accept;
  logic               any_fired;
  logic               arb_run;
  logic               drained;
  logic [LANES*ACC_W-1:0] acc;

  assign accept = start && (phase_q == PH_IDLE);

  spike_bus_arbiter #(
    .NUM_PE (NUM_PE),
    .CNT_W  (CNT_W),
    .PTR_W  (PTR_W)
  ) arb_i (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .pe_count  (pe_count),
    .any_fired (any_fired),
    .run       (arb_run),
    .gnt       (bus_gnt),
    .ptr       (bus_ptr)
  );

  spike_req_issue #(
    .IDX_W   (IDX_W),
    .GRP_W   (GRP_W),
    .MEM_LAT (MEM_LAT)
  ) iss_i (
    .clk        (clk),
    .rst        (rst),
    .fetch      (|bus_gnt),
    .bus_idx    (bus_idx),
    .grp        (grp_q),
    .mem_rvalid (mem_rvalid),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .drained    (drained)
  );

  spike_lane_accum #(
    .LANES    (LANES),
    .WEIGHT_W (WEIGHT_W),
    .ACC_W    (ACC_W)
  ) acc_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (accept),
    .add   (mem_rvalid),
    .rdata (mem_rdata),
    .acc   (acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      grp_q     <= '0;
      done      <= 1'b0;
      cur_valid <= 1'b0;
      cur_grp   <= '0;
      cur_data  <= '0;
    end else begin
      done      <= 1'b0;
      cur_valid <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            grp_q <= grp_sel;
            if (any_fired) begin
              phase_q <= PH_RUN;
            end else begin
              done <= 1'b1;
            end
          end
        end
        PH_RUN: begin
          if (!arb_run && (bus_gnt == '0) && drained) begin
            phase_q   <= PH_IDLE;
            done      <= 1'b1;
            cur_valid <= 1'b1;
            cur_grp   <= grp_q;
            cur_data  <= acc;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy = (phase_q == PH_RUN);

  AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    cur_valid |-> done); // R7
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !cur_valid) |-> $stable(cur_data)); // R8
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> (bus_gnt == '0)); // R9

endmodule

// File: tb/spike_current_accum_tb.sv
module spike_current_accum_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_PE     = 4;
  localparam int LIST_DEPTH = 8;
  localparam int IDX_W      = 8;
  localparam int GRP_W      = 4;
  localparam int LANES      = 4;
  localparam int WEIGHT_W   = 16;
  localparam int MEM_LAT    = 11;
  localparam int CNT_W      = 4;
  localparam int PTR_W      = 3;
  localparam int ADDR_W     = GRP_W + IDX_W;
  localparam int ACC_W      = 22;
  localparam int NVEC       = 6;

  // Stimulus table: per-element counts (element 0 in lowest nibble) and group
  localparam logic [15:0] VEC_CNT [NVEC] = '{16'h1111, 16'h8888, 16'h0300, 16'h5020, 16'h0001, 16'h8000};
  localparam logic [3:0]  VEC_GRP [NVEC] = '{4'd0, 4'd15, 4'd3, 4'd7, 4'd9, 4'd1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [GRP_W-1:0] grp_sel = '0;
  logic [NUM_PE*CNT_W-1:0] pe_count = '0;
  logic busy, done, mem_req, mem_rvalid, cur_valid;
  logic [NUM_PE-1:0] bus_gnt;
  logic [PTR_W-1:0] bus_ptr;
  logic [IDX_W-1:0] bus_idx;
  logic [ADDR_W-1:0] mem_addr;
  logic [LANES*WEIGHT_W-1:0] mem_rdata;
  logic [GRP_W-1:0] cur_grp;
  logic [LANES*ACC_W-1:0] cur_data;

  int lst [NUM_PE][LIST_DEPTH];
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  int n_req = 0;
  int n_rv = 0;
  int first_req = 0;
  int last_req = 0;
  logic [ADDR_W-1:0] addr_log [64];

  logic [MEM_LAT-1:0] pv;
  logic [ADDR_W-1:0]  pa [MEM_LAT];

  always #(CLK_PERIOD/2) clk = ~clk;

  spike_current_accum dut_i (
    .clk(clk), .rst(rst), .start(start), .grp_sel(grp_sel), .pe_count(pe_count),
    .busy(busy), .done(done), .bus_gnt(bus_gnt), .bus_ptr(bus_ptr), .bus_idx(bus_idx),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .cur_valid(cur_valid), .cur_grp(cur_grp), .cur_data(cur_data)
  );

  function automatic logic [15:0] wgt(int g, int idx, int lane);
    if (idx == 255) return 16'h8000;
    if (idx == 254) return 16'h7fff;
    return 16'(((idx * 37 + g * 11 + lane * 101) % 8192) - 4096);
  endfunction

  function automatic logic [LANES*WEIGHT_W-1:0] word_at(logic [ADDR_W-1:0] a);
    logic [LANES*WEIGHT_W-1:0] w;
    for (int l = 0; l < LANES; l++)
      w[l*WEIGHT_W +: WEIGHT_W] = wgt(int'(a[ADDR_W-1:IDX_W]), int'(a[IDX_W-1:0]), l);
    return w;
  endfunction

  // Processing elements: combinational list read on grant
  always_comb begin
    bus_idx = '0;
    for (int p = 0; p < NUM_PE; p++)
      if (bus_gnt[p]) bus_idx = IDX_W'(lst[p][bus_ptr]);
  end

  // Weight memory: fixed-latency shift line
  always @(posedge clk) begin
    if (rst) pv <= '0;
    else pv <= {pv[MEM_LAT-2:0], mem_req};
    pa[0] <= mem_addr;
    for (int i = 1; i < MEM_LAT; i++) pa[i] <= pa[i-1];
  end
  assign mem_rvalid = pv[MEM_LAT-1];
  assign mem_rdata  = word_at(pa[MEM_LAT-1]);

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor and watchdog
  always @(posedge clk) begin
    cyc++;
    if (mon_en) begin
      if (mem_req) begin
        if (n_req < 64) addr_log[n_req] = mem_addr;
        if (n_req == 0) first_req = cyc;
        last_req = cyc;
        n_req++;
      end
      if (mem_rvalid) n_rv++;
    end
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL R7 watchdog: actual=no finish expected=finish");
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: computed indices, 1: all 255 (most negative), 2: all 254 (most positive)
  task automatic run_case(input int vi, input logic [3:0] g, input logic [15:0] cnts, input int mode);
    longint exp_sum [LANES];
    int total = 0;
    int bad_addr = 0;
    int w = 0;
    int k = 0;
    for (int l = 0; l < LANES; l++) exp_sum[l] = 0;
    for (int p = 0; p < NUM_PE; p++)
      for (int e = 0; e < LIST_DEPTH; e++)
        lst[p][e] = (mode == 1) ? 255 : (mode == 2) ? 254 : ((vi * 29 + p * 13 + e * 7 + 3) % 250);
    for (int p = 0; p < NUM_PE; p++)
      for (int e = 0; e < int'(cnts[p*4 +: 4]); e++) begin
        total++;
        for (int l = 0; l < LANES; l++) exp_sum[l] += longint'($signed(wgt(int'(g), lst[p][e], l)));
      end
    pe_count = cnts;
    grp_sel  = g;
    n_req = 0; n_rv = 0; mon_en = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", longint'(busy), 1);
    while (!done && w < 1000) begin
      @(negedge clk);
      w++;
    end
    chk("R7 done seen", longint'(done), 1);
    chk("R7 cur_valid with done", longint'(cur_valid), 1);
    chk("R9 busy low at done", longint'(busy), 0);
    chk("R7 cur_grp", longint'(cur_grp), longint'(g));
    chk("R7 responses before done", longint'(n_rv), longint'(total));
    chk("R3 request count", longint'(n_req), longint'(total));
    chk("R3 unbroken request run", longint'(last_req - first_req), longint'(total - 1));
    for (int p = 0; p < NUM_PE; p++)
      for (int e = 0; e < int'(cnts[p*4 +: 4]); e++) begin
        if (k < 64 && addr_log[k] != {g, IDX_W'(lst[p][e])}) bad_addr++;
        k++;
      end
    chk("R2 R3 address order", longint'(bad_addr), 0);
    for (int l = 0; l < LANES; l++) begin
      longint a;
      a = longint'($signed(cur_data[l*ACC_W +: ACC_W]));
      chk((mode == 0) ? "R4 R5 lane sum" : "R6 extreme lane sum", a, exp_sum[l]);
    end
    mon_en = 1'b0;
    @(negedge clk);
    chk("R7 done is one pulse", longint'(done), 0);
  endtask

  initial begin
    logic [LANES*ACC_W-1:0] prev;
    repeat (5) @(negedge clk);
    chk("R1 busy in reset", longint'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done", longint'(done), 0);
    chk("R1 cur_valid", longint'(cur_valid), 0);
    chk("R1 mem_req", longint'(mem_req), 0);
    chk("R1 bus_gnt", longint'(bus_gnt), 0);
    chk("R1 cur_data", longint'(cur_data == '0), 1);

    for (int v = 0; v < NVEC; v++) run_case(v, VEC_GRP[v], VEC_CNT[v], 0);

    run_case(10, 4'd5, 16'h8888, 1);
    run_case(11, 4'd6, 16'h8888, 2);

    // R8: empty lists
    prev = cur_data;
    pe_count = '0;
    grp_sel  = 4'd2;
    n_req = 0; mon_en = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 done next cycle", longint'(done), 1);
    chk("R8 cur_valid low", longint'(cur_valid), 0);
    chk("R8 busy low", longint'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R8 no request", longint'(n_req), 0);
    chk("R8 cur_data unchanged", longint'(cur_data == prev), 1);
    mon_en = 1'b0;

    // R5: fresh phase after the extreme run starts from zero
    run_case(3, 4'd12, 16'h0210, 0);

    summary();
    $finish;
  end

endmodule